// File: doc/BRIEF.md
# Accumulator ALU with Packed Status Flags

This block is the 8-bit arithmetic and logic stage of a small accumulator machine. Each operation takes the accumulator, a second operand, the incoming carry and a 4-bit operation code. It produces a result and a packed status byte. The operations are: plain and carried addition, plain and borrowed subtraction, compare, the three bitwise operations, two's-complement negation, accumulator inversion, forcing carry to 1 and inverting carry. One status bit has two meanings. It holds signed overflow after arithmetic and even parity after the bitwise operations. Half-carry and an add/subtract marker sit in bits of their own.

The arithmetic itself is combinational. A capture stage built as a two-state machine stores the result, the status byte and a write-back marker on each cycle that `strobe` is high. A surrounding datapath writes `res_q` into the accumulator only when `wb_q` is 1. Compare, force-carry and invert-carry therefore leave the accumulator alone. The machine starts in state ST_EMPTY after reset. Transition T_FIRST_CAPTURE moves it to ST_LOADED on the first strobe. In ST_LOADED, transition T_RECAPTURE reloads the outputs on each later strobe. Transition T_IDLE_HOLD keeps either state and all outputs unchanged while `strobe` is low.

Top module: `acc_alu_unit`

## Requirements
- R1: Status byte layout: bit 7 sign, bit 6 zero, bit 4 half-carry, bit 2 parity/overflow, bit 1 subtract marker, bit 0 carry. Bits 5 and 3 are always 0. Sign copies bit 7 of the flag value and zero is 1 when all 8 bits of that value are 0. The flag value is the result for every code except compare (code 4), where it is the difference.
- R2: Code 0 (add) gives A+B and code 1 (add with carry) gives A+B+carry_in, both modulo 256. Carry is the carry out of bit 7 and half-carry is the carry out of bit 3.
- R3: For codes 0 to 4 and code 8, the parity/overflow bit is 1 exactly when the signed two's-complement result falls outside -128..127.
- R4: Code 2 (subtract) gives A-B and code 3 (subtract with borrow) gives A-B-carry_in, both modulo 256. Carry is 1 when the true difference is negative. Half-carry is 1 when the low-nibble difference is negative.
- R5: Code 4 (compare) sets the flags exactly as subtract would. `res_q` then equals the accumulator input and `wb_q` is 0.
- R6: Codes 5/6/7 (AND/OR/XOR) give the bitwise result. Parity/overflow is 1 when that result has an even number of set bits. Carry and the subtract marker are 0. Half-carry is 1 for AND and 0 for OR and XOR.
- R7: Code 8 (negate) gives 0-A modulo 256, with flags as subtract from zero: carry is 1 when A is not 0, and overflow is 1 when A is 0x80.
- R8: Code 9 (complement) gives the bitwise inverse of A with half-carry 1, subtract marker 1, parity/overflow 0 and carry equal to carry_in.
- R9: Code 10 (force carry) sets carry 1 and half-carry 0. Code 11 (invert carry) sets carry to NOT carry_in and half-carry to carry_in. Both have subtract marker 0 and parity/overflow 0, and both return `res_q` equal to A with `wb_q` 0.
- R10: The subtract marker is 0 after codes 0, 1 and 5 to 7 and 1 after codes 2, 3, 4, 8 and 9.
- R11: Reset clears `res_q`, `flags_q`, `wb_q` and `valid_q`. A strobe updates all outputs on the next clock edge and sets `valid_q`. Without a strobe, every output holds its value.
- R12: Codes 12 to 15 return `res_q` equal to A with `wb_q` 0. All status bits are 0 except carry, which equals carry_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Capture the current operation |
| op_sel | input | 4 | Operation code, see requirements |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| carry_in | input | 1 | Incoming carry flag |
| res_q | output | 8 | Captured result |
| flags_q | output | 8 | Captured status byte |
| wb_q | output | 1 | Result is to be written to the accumulator |
| valid_q | output | 1 | At least one operation captured since reset |

## Verification
The two-operand codes run with every accumulator value against 32 second-operand values. These include 0x00, 0x7F, 0x80 and 0xFF, and the incoming carry alternates between vectors. This exercises signed overflow on both sides, nibble carries and borrows, and zero results. The single-operand, carry-only and unused codes run over all 256 accumulator values with both carry levels. This separates the carry-only codes, which take flags from carry_in, from the codes whose flags come from the result. Reset and idle-hold checks with no strobe confirm that the capture stage changes only on a strobe.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;

    localparam logic [3:0] OP_ADD = 4'd0;
    localparam logic [3:0] OP_ADC = 4'd1;
    localparam logic [3:0] OP_SUB = 4'd2;
    localparam logic [3:0] OP_SBC = 4'd3;
    localparam logic [3:0] OP_CMP = 4'd4;
    localparam logic [3:0] OP_AND = 4'd5;
    localparam logic [3:0] OP_OR  = 4'd6;
    localparam logic [3:0] OP_XOR = 4'd7;
    localparam logic [3:0] OP_NEG = 4'd8;
    localparam logic [3:0] OP_CPL = 4'd9;
    localparam logic [3:0] OP_SCF = 4'd10;
    localparam logic [3:0] OP_CCF = 4'd11;

    localparam int FB_SIGN = 7;
    localparam int FB_ZERO = 6;
    localparam int FB_HALF = 4;
    localparam int FB_PV   = 2;
    localparam int FB_SUBM = 1;
    localparam int FB_CARRY = 0;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } flag_set_t;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } cap_state_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         co,
    output logic         hc,
    output logic         ov
);
    localparam int HW = W / 2;

    logic [W:0]  full;
    logic [HW:0] low;

    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, ci};
            low  = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]} - {{HW{1'b0}}, ci};
            ov   = (a[W-1] ^ b[W-1]) & (full[W-1] ^ a[W-1]);
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
            low  = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, ci};
            ov   = ~(a[W-1] ^ b[W-1]) & (full[W-1] ^ a[W-1]);
        end
        r  = full[W-1:0];
        co = full[W];
        hc = low[HW];
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] r,
    output logic         even_par
);
    always_comb begin
        unique case (sel)
            2'd0:    r = a & b;
            2'd1:    r = a | b;
            default: r = a ^ b;
        endcase
        even_par = ~(^r);
    end
endmodule

// File: rtl/alu_flag_pack.sv
module alu_flag_pack
    import acc_alu_pkg::*;
(
    input  flag_set_t  fl,
    output logic [7:0] fbyte
);
    always_comb begin
        fbyte           = '0;
        fbyte[FB_SIGN]  = fl.s;
        fbyte[FB_ZERO]  = fl.z;
        fbyte[FB_HALF]  = fl.h;
        fbyte[FB_PV]    = fl.pv;
        fbyte[FB_SUBM]  = fl.n;
        fbyte[FB_CARRY] = fl.c;
    end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [3:0]   op_sel,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] opnd_in,
    input  logic         carry_in,
    output logic [W-1:0] res_q,
    output logic [7:0]   flags_q,
    output logic         wb_q,
    output logic         valid_q
);
    logic [W-1:0] ar_a, ar_b, ar_r, lg_r;
    logic         ar_ci, ar_sub, ar_co, ar_hc, ar_ov, lg_par;
    logic [W-1:0] res_d, fv;
    logic         wb_d, sz_en;
    flag_set_t    fl_d;
    logic [7:0]   fbyte_d;
    cap_state_e   state, state_nx;

    always_comb begin
        ar_a   = (op_sel == OP_NEG) ? '0 : acc_in;
        ar_b   = (op_sel == OP_NEG) ? acc_in : opnd_in;
        ar_ci  = (op_sel == OP_ADC || op_sel == OP_SBC) ? carry_in : 1'b0;
        ar_sub = (op_sel == OP_SUB || op_sel == OP_SBC ||
                  op_sel == OP_CMP || op_sel == OP_NEG);
    end

    alu_addsub #(.W(W)) u_addsub (
        .a(ar_a), .b(ar_b), .ci(ar_ci), .sub(ar_sub),
        .r(ar_r), .co(ar_co), .hc(ar_hc), .ov(ar_ov)
    );

    alu_bitwise #(.W(W)) u_bitwise (
        .a(acc_in), .b(opnd_in), .sel(op_sel[1:0] - 2'd1),
        .r(lg_r), .even_par(lg_par)
    );

    always_comb begin
        res_d = acc_in;
        fv    = acc_in;
        wb_d  = 1'b0;
        sz_en = 1'b1;
        fl_d  = '0;
        fl_d.c = carry_in;
        unique case (op_sel)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                res_d = ar_r; fv = ar_r; wb_d = 1'b1;
                fl_d.h = ar_hc; fl_d.pv = ar_ov; fl_d.n = ar_sub; fl_d.c = ar_co;
            end
            OP_CMP: begin
                fv = ar_r;
                fl_d.h = ar_hc; fl_d.pv = ar_ov; fl_d.n = 1'b1; fl_d.c = ar_co;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_d = lg_r; fv = lg_r; wb_d = 1'b1;
                fl_d.h = (op_sel == OP_AND); fl_d.pv = lg_par;
                fl_d.n = 1'b0; fl_d.c = 1'b0;
            end
            OP_CPL: begin
                res_d = ~acc_in; fv = ~acc_in; wb_d = 1'b1;
                fl_d.h = 1'b1; fl_d.n = 1'b1;
            end
            OP_SCF: begin
                fl_d.c = 1'b1;
            end
            OP_CCF: begin
                fl_d.h = carry_in; fl_d.c = ~carry_in;
            end
            default: begin
                sz_en = 1'b0;
            end
        endcase
        fl_d.s = sz_en & fv[W-1];
        fl_d.z = sz_en & (fv == '0);
    end

    alu_flag_pack u_pack (.fl(fl_d), .fbyte(fbyte_d));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_EMPTY:  state_nx = strobe ? ST_LOADED : ST_EMPTY;  // T_FIRST_CAPTURE / T_IDLE_HOLD
            ST_LOADED: state_nx = ST_LOADED;                      // T_RECAPTURE / T_IDLE_HOLD
            default:   state_nx = ST_EMPTY;
        endcase
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
            wb_q    <= 1'b0;
        end else if (strobe) begin
            res_q   <= res_d;
            flags_q <= fbyte_d;
            wb_q    <= wb_d;
        end
    end

    assign valid_q = (state == ST_LOADED);

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       strobe,
    input logic [3:0] op_sel,
    input logic [7:0] acc_in,
    input logic [7:0] res_q,
    input logic [7:0] flags_q,
    input logic       wb_q,
    input logic       valid_q
);
    AST_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> (res_q == 8'd0 && flags_q == 8'd0 && !wb_q)); // R11
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !strobe) |=> ($stable(res_q) && $stable(flags_q) && $stable(wb_q))); // R11
    AST_SPARE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[5] == 1'b0 && flags_q[3] == 1'b0)); // R1
    AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && wb_q) |-> (flags_q[6] == (res_q == 8'd0))); // R1
    AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && wb_q) |-> (flags_q[7] == res_q[7])); // R1
    AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && (op_sel == 4'd5 || op_sel == 4'd6 || op_sel == 4'd7))
        |=> (flags_q[0] == 1'b0 && flags_q[1] == 1'b0)); // R6
    AST_SUB_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && (op_sel == 4'd2 || op_sel == 4'd3 || op_sel == 4'd4 || op_sel == 4'd8))
        |=> flags_q[1]); // R10
    AST_CMP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op_sel == 4'd4) |=> (!wb_q && res_q == $past(acc_in))); // R5
    AST_FORCE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op_sel == 4'd10) |=> (flags_q[0] && !wb_q)); // R9
endmodule

bind acc_alu_unit acc_alu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .op_sel(op_sel),
    .acc_in(acc_in), .res_q(res_q), .flags_q(flags_q),
    .wb_q(wb_q), .valid_q(valid_q)
);

// File: tb/acc_alu_unit_test.sv
module acc_alu_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] acc_in = '0, opnd_in = '0;
    logic       carry_in = 1'b0;
    logic [7:0] res_q, flags_q;
    logic       wb_q, valid_q;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu_unit uut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .op_sel(op_sel),
        .acc_in(acc_in), .opnd_in(opnd_in), .carry_in(carry_in),
        .res_q(res_q), .flags_q(flags_q), .wb_q(wb_q), .valid_q(valid_q)
    );

    function automatic string tag_of(input int op);
        case (op)
            0, 1:    return "R2/R3/R10";
            2, 3:    return "R4/R3/R10";
            4:       return "R5/R1";
            5, 6, 7: return "R6/R10";
            8:       return "R7/R3";
            9:       return "R8";
            10, 11:  return "R9";
            default: return "R12";
        endcase
    endfunction

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    task automatic model(input int op, input int a, input int b, input int ci,
                         output logic [7:0] er, output logic [7:0] ef, output logic ew);
        int r, fvv, s, z, h, pv, n, c, t, ones;
        r = a; fvv = a; ew = 1'b0; s = 0; z = 0; h = 0; pv = 0; n = 0; c = ci;
        case (op)
            0, 1: begin
                t = (op == 1) ? ci : 0;
                r = a + b + t; c = (r > 255) ? 1 : 0; r = r % 256;
                h = ((a % 16) + (b % 16) + t > 15) ? 1 : 0;
                s = sgn(a) + sgn(b) + t; pv = (s > 127 || s < -128) ? 1 : 0;
                fvv = r; ew = 1'b1;
            end
            2, 3, 4, 8: begin
                int x, y;
                x = (op == 8) ? 0 : a; y = (op == 8) ? a : b;
                t = (op == 3) ? ci : 0;
                r = x - y - t; c = (r < 0) ? 1 : 0; r = (r + 512) % 256;
                h = ((x % 16) - (y % 16) - t < 0) ? 1 : 0;
                s = sgn(x) - sgn(y) - t; pv = (s > 127 || s < -128) ? 1 : 0;
                n = 1; fvv = r;
                if (op == 4) r = a; else ew = 1'b1;
            end
            5, 6, 7: begin
                r = (op == 5) ? (a & b) : (op == 6) ? (a | b) : (a ^ b);
                ones = 0;
                for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
                pv = (ones % 2 == 0) ? 1 : 0; h = (op == 5) ? 1 : 0;
                c = 0; fvv = r; ew = 1'b1;
            end
            9: begin r = 255 - a; fvv = r; h = 1; n = 1; ew = 1'b1; end
            10: c = 1;
            11: begin h = ci; c = 1 - ci; end
            default: fvv = -1;
        endcase
        if (fvv >= 0) begin
            s = (fvv >= 128) ? 1 : 0;
            z = (fvv == 0) ? 1 : 0;
        end else begin
            s = 0; z = 0;
        end
        er = r[7:0];
        ef = 8'(s * 128 + z * 64 + h * 16 + pv * 4 + n * 2 + c);
    endtask

    task automatic apply(input int op, input int a, input int b, input int ci);
        logic [7:0] er, ef;
        logic ew;
        op_sel = 4'(op); acc_in = 8'(a); opnd_in = 8'(b); carry_in = ci[0];
        strobe = 1'b1;
        @(negedge clk);
        model(op, a, b, ci, er, ef, ew);
        n_vec++;
        if (res_q !== er || flags_q !== ef || wb_q !== ew || valid_q !== 1'b1) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%02h b=%02h c=%0d: res/flags/wb/valid = %02h/%02h/%0b/%0b expected %02h/%02h/%0b/1",
                     tag_of(op), op, a, b, ci, res_q, flags_q, wb_q, valid_q, er, ef, ew);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int cyc = 0; cyc < WATCHDOG_CYCLES; cyc++) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: cycles %0d expected fewer", WATCHDOG_CYCLES);
        finish_run();
    end

    initial begin
        logic [7:0] keep_r, keep_f;
        repeat (3) @(negedge clk);
        // R11: reset state
        n_vec++;
        if (res_q !== 8'h00 || flags_q !== 8'h00 || wb_q !== 1'b0 || valid_q !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 reset: %02h/%02h/%0b/%0b expected 00/00/0/0", res_q, flags_q, wb_q, valid_q);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R11: no strobe keeps empty state
        op_sel = 4'd0; acc_in = 8'hFF; opnd_in = 8'h01;
        @(negedge clk);
        n_vec++;
        if (valid_q !== 1'b0 || res_q !== 8'h00) begin
            n_bad++;
            $display("FAIL R11 idle before strobe: valid=%0b res=%02h expected 0/00", valid_q, res_q);
        end

        // two-operand codes: R2 R3 R4 R5 R6 R10 R1
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 256; a++)
                for (int j = 0; j < 32; j++)
                    apply(op, a, j * 8 + (j % 8), (a ^ j) & 1);

        // single-operand, carry-only and unused codes: R7 R8 R9 R12
        for (int op = 8; op < 16; op++)
            for (int a = 0; a < 256; a++)
                for (int ci = 0; ci < 2; ci++)
                    apply(op, a, 255 - a, ci);

        // R11: outputs hold without a strobe
        apply(0, 8'h7F, 8'h01, 0);
        keep_r = res_q; keep_f = flags_q;
        strobe = 1'b0; op_sel = 4'd9; acc_in = 8'h00; carry_in = 1'b1;
        @(negedge clk); @(negedge clk);
        n_vec++;
        if (res_q !== keep_r || flags_q !== keep_f || wb_q !== 1'b1) begin
            n_bad++;
            $display("FAIL R11 hold: %02h/%02h expected %02h/%02h", res_q, flags_q, keep_r, keep_f);
        end
        finish_run();
    end
endmodule